// File: doc/BRIEF.md
# System Coprocessor Access Decoder

This block sits beside a processor core and serves the system-control coprocessor, which is coprocessor number 15. The core presents a 32-bit coprocessor instruction word with a one-cycle valid strobe. It also presents a flag that says whether the core is in a privileged mode, and the contents of a core register for writes. The block works out whether the word is a register transfer meant for this coprocessor. If it is, the block either returns the selected register or stores the write data into it. If the word is some other kind of instruction for this coprocessor, or a transfer tried from user mode, the block raises a trap so that the core can take its undefined-instruction exception. Words meant for other coprocessors are left for those coprocessors.

The register file is small. It holds a read-only identification word, a control register and a parameterised number of plain read/write registers. In the control register, one bit sets where the exception vectors are placed. That bit takes its reset value from an input pin. Every other stored bit resets to zero. Result flags and read data appear one clock after the strobe.

Top module: `sysctl_cop_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, `xfer_accept`, `undef_trap` and `core_rdata` clear, every register bit clears, and control bit `VEC_BIT` (default 13) loads `vec_init`.
- R2: A valid word with coprocessor field [11:8]=4'hF, major field [27:24]=4'hE and bit [4]=1, presented with `priv_mode` high, gives a one-cycle `xfer_accept` pulse in the cycle after the strobe.
- R3: An accepted transfer with direction bit [20]=1 places the register selected by [19:16] on `core_rdata` in the same cycle as `xfer_accept`. `core_rdata` holds that value until the next accepted read.
- R4: An accepted transfer with [20]=0 stores `core_wdata` into the register selected by [19:16] at the clock edge that ends the strobe cycle. A read in the next cycle returns the new value.
- R5: A transfer with `priv_mode` low gives `undef_trap` and no `xfer_accept`, and leaves every register and `core_rdata` unchanged.
- R6: A word for coprocessor 15 with [27:24]=4'hE and [4]=0 (data operation), or with [27:25]=3'b110 (memory transfer), gives `undef_trap` one cycle later in either mode, and changes no state.
- R7: A word whose [11:8] is not 4'hF, or a coprocessor-15 word that matches none of the forms in R2 and R6, gives neither flag and changes no state.
- R8: `xfer_accept` and `undef_trap` are never high together, and both are low in any cycle that does not follow a strobe.
- R9: Register 0 reads as the constant `ID_VALUE` (default 32'h5C0D_0001). Writes to it are discarded.
- R10: Register numbers with no register behind them read as zero. Writes to them are discarded.
- R11: The control register (register 1) stores only its low `CTRL_W` bits (default 14). Its upper bits read as zero.
- R12: Registers 2 and 3 (`RW_FIRST` to `RW_FIRST+NUM_RW-1`) store all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vec_init | input | 1 | Reset value of the vector-location control bit |
| insn_valid | input | 1 | Instruction word strobe |
| insn_word | input | 32 | Coprocessor instruction word |
| priv_mode | input | 1 | High when the core is in a privileged mode |
| core_wdata | input | 32 | Core register value for writes |
| core_rdata | output | 32 | Register value returned by reads |
| xfer_accept | output | 1 | Transfer completed, one-cycle pulse |
| undef_trap | output | 1 | Undefined-instruction trap, one-cycle pulse |

## Verification
The hardest case to reach is proving that a rejected word leaves no trace. A trap or an ignored word shows nothing on the data port. So the stimulus first writes known patterns into the registers. It then sends unprivileged writes, data-operation and memory-transfer words, and writes for another coprocessor, all aimed at those registers. After that it reads every register back through privileged transfers. Reset is applied twice with opposite `vec_init` levels, which shows that only the vector bit follows the pin.

// File: rtl/sysctl_pkg.sv
// Shared constants for the system coprocessor access decoder.
// Assumes the fixed field layout of coprocessor instruction words.
package sysctl_pkg;
    localparam logic [3:0] COP_NUM    = 4'hF;   // coprocessor number served
    localparam logic [3:0] MAJOR_COP  = 4'hE;   // data-op / transfer major field
    localparam logic [2:0] MAJOR_MEM  = 3'b110; // memory transfer major field
    localparam logic [3:0] SEL_ID     = 4'd0;
    localparam logic [3:0] SEL_CTRL   = 4'd1;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_XFER  = 2'd1,
        CLS_TRAP  = 2'd2
    } op_class_e;
endpackage

// File: rtl/sysctl_insn_classify.sv
// Combinational classifier: sorts a strobed instruction word into
// accepted transfer, trap or not-ours, and extracts direction and CRn.
// Assumes opcode and CRm selectors are zero; they are not decoded.
module sysctl_insn_classify
    import sysctl_pkg::*;
(
    input  logic        insn_valid,
    input  logic [31:0] insn_word,
    input  logic        priv_mode,
    output op_class_e   op_class,
    output logic        is_read,
    output logic [3:0]  reg_sel
);
    logic ours;
    logic cop_major;
    logic mem_major;
    logic xfer_form;
    logic unused_fields;

    assign unused_fields = ^{insn_word[31:28], insn_word[23:21], insn_word[15:12],
                             insn_word[7:5], insn_word[3:0]};

    // Field tests on the raw word.
    always_comb begin
        ours      = (insn_word[11:8] == COP_NUM);
        cop_major = (insn_word[27:24] == MAJOR_COP);
        mem_major = (insn_word[27:25] == MAJOR_MEM);
        xfer_form = cop_major && insn_word[4];
    end

    // Class decision with privilege check.
    always_comb begin
        op_class = CLS_NONE;
        if (insn_valid && ours) begin
            if (xfer_form)
                op_class = priv_mode ? CLS_XFER : CLS_TRAP;
            else if (cop_major || mem_major)
                op_class = CLS_TRAP;
        end
    end

    assign is_read = insn_word[20];
    assign reg_sel = insn_word[19:16];
endmodule

// File: rtl/sysctl_reg_bank.sv
// Register file of the coprocessor: read-only ID word, control register
// with a pin-loaded vector bit, and NUM_RW full-width read/write registers.
// Assumes wr_en and rd_en are never high together.
module sysctl_reg_bank
    import sysctl_pkg::*;
#(
    parameter logic [31:0] ID_VALUE = 32'h5C0D_0001,
    parameter int          CTRL_W   = 14,
    parameter int          VEC_BIT  = 13,
    parameter int          RW_FIRST = 2,
    parameter int          NUM_RW   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vec_init,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [3:0]  reg_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data
);
    localparam int PAD_W = 32 - CTRL_W;

    logic [CTRL_W-1:0] ctrl_q;
    logic [31:0]       rw_q [NUM_RW];
    logic [31:0]       rd_next;

    // Control register: reset clears all but the vector bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q          <= '0;
            ctrl_q[VEC_BIT] <= vec_init;
        end else if (wr_en && reg_sel == SEL_CTRL) begin
            ctrl_q <= wr_data[CTRL_W-1:0];
        end
    end

    // Plain read/write registers, one per generated slot.
    for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
        localparam logic [3:0] SLOT = 4'(RW_FIRST + g);
        always_ff @(posedge clk) begin
            if (!rst_n)
                rw_q[g] <= '0;
            else if (wr_en && reg_sel == SLOT)
                rw_q[g] <= wr_data;
        end
    end

    // Read multiplexer: undefined selections return zero.
    always_comb begin
        rd_next = '0;
        if (reg_sel == SEL_ID)
            rd_next = ID_VALUE;
        else if (reg_sel == SEL_CTRL)
            rd_next = {{PAD_W{1'b0}}, ctrl_q};
        for (int i = 0; i < NUM_RW; i++)
            if (reg_sel == 4'(RW_FIRST + i))
                rd_next = rw_q[i];
    end

    // Read data register, updated only by accepted reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_next;
    end
endmodule

// File: rtl/sysctl_resp_flags.sv
// Registers the accept and trap pulses one cycle after the strobe.
// Assumes op_class is already qualified by the strobe.
module sysctl_resp_flags
    import sysctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  op_class_e op_class,
    output logic      accept_q,
    output logic      trap_q
);
    // Pulse flags follow the class of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_q <= 1'b0;
            trap_q   <= 1'b0;
        end else begin
            accept_q <= (op_class == CLS_XFER);
            trap_q   <= (op_class == CLS_TRAP);
        end
    end
endmodule

// File: rtl/sysctl_cop_decoder.sv
// Top of the system coprocessor access decoder: classifies each strobed
// word, performs privileged register transfers and raises the trap.
// Assumes one word per strobe cycle; condition codes are already resolved.
module sysctl_cop_decoder
    import sysctl_pkg::*;
#(
    parameter logic [31:0] ID_VALUE = 32'h5C0D_0001,
    parameter int          CTRL_W   = 14,
    parameter int          VEC_BIT  = 13,
    parameter int          RW_FIRST = 2,
    parameter int          NUM_RW   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vec_init,
    input  logic        insn_valid,
    input  logic [31:0] insn_word,
    input  logic        priv_mode,
    input  logic [31:0] core_wdata,
    output logic [31:0] core_rdata,
    output logic        xfer_accept,
    output logic        undef_trap
);
    op_class_e  op_class;
    logic       is_read;
    logic [3:0] reg_sel;
    logic       wr_en;
    logic       rd_en;

    sysctl_insn_classify u_classify (
        .insn_valid (insn_valid),
        .insn_word  (insn_word),
        .priv_mode  (priv_mode),
        .op_class   (op_class),
        .is_read    (is_read),
        .reg_sel    (reg_sel)
    );

    // Transfer enables derived from the accepted class.
    always_comb begin
        wr_en = (op_class == CLS_XFER) && !is_read;
        rd_en = (op_class == CLS_XFER) &&  is_read;
    end

    sysctl_reg_bank #(
        .ID_VALUE (ID_VALUE),
        .CTRL_W   (CTRL_W),
        .VEC_BIT  (VEC_BIT),
        .RW_FIRST (RW_FIRST),
        .NUM_RW   (NUM_RW)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .vec_init (vec_init),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .reg_sel  (reg_sel),
        .wr_data  (core_wdata),
        .rd_data  (core_rdata)
    );

    sysctl_resp_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_class (op_class),
        .accept_q (xfer_accept),
        .trap_q   (undef_trap)
    );
endmodule

// File: rtl/sysctl_cop_decoder_chk.sv
// Assertion checker for the coprocessor decoder, bound to the top module.
module sysctl_cop_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        insn_valid,
    input logic [31:0] insn_word,
    input logic        priv_mode,
    input logic [31:0] core_rdata,
    input logic        xfer_accept,
    input logic        undef_trap
);
    // R8: flags never together
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_accept && undef_trap));

    // R8: no pulse without a strobe one cycle earlier
    a_r8_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |=> !xfer_accept && !undef_trap);

    // R5: accept only follows a privileged cycle
    a_r5_priv_only: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_accept |-> $past(priv_mode));

    // R7: other coprocessors are ignored
    a_r7_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_word[11:8] != 4'hF) |=> !xfer_accept && !undef_trap);

    // R6: data-operation form always traps
    a_r6_dataop_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_word[11:8] == 4'hF && insn_word[27:24] == 4'hE
         && !insn_word[4]) |=> undef_trap);

    // R3: read data holds when no word was strobed
    a_r3_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |=> $stable(core_rdata));
endmodule

bind sysctl_cop_decoder sysctl_cop_decoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .insn_valid  (insn_valid),
    .insn_word   (insn_word),
    .priv_mode   (priv_mode),
    .core_rdata  (core_rdata),
    .xfer_accept (xfer_accept),
    .undef_trap  (undef_trap)
);

// File: tb/sysctl_cop_decoder_test.sv
module sysctl_cop_decoder_test;
    localparam logic [31:0] ID_V = 32'h5C0D_0001;
    localparam int CW = 14;
    localparam int VB = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vec_init = 1'b1;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic        priv_mode = 1'b0;
    logic [31:0] core_wdata = '0;
    logic [31:0] core_rdata;
    logic        xfer_accept;
    logic        undef_trap;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sysctl_cop_decoder uut (
        .clk(clk), .rst_n(rst_n), .vec_init(vec_init), .insn_valid(insn_valid),
        .insn_word(insn_word), .priv_mode(priv_mode), .core_wdata(core_wdata),
        .core_rdata(core_rdata), .xfer_accept(xfer_accept), .undef_trap(undef_trap)
    );

    // Behavioural reference model
    logic [31:0] m_reg [16];
    logic [31:0] m_rd;
    logic        m_acc, m_trap;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_reg[i] = 0;
            m_reg[1][VB] = vec_init;
            m_rd = 0; m_acc = 0; m_trap = 0;
        end else begin
            m_acc = 0; m_trap = 0;
            if (insn_valid && insn_word[11:8] == 4'hF) begin
                if (insn_word[27:24] == 4'hE && insn_word[4]) begin
                    if (!priv_mode) m_trap = 1;
                    else begin
                        m_acc = 1;
                        if (insn_word[20]) begin
                            case (insn_word[19:16])
                                0: m_rd = ID_V;
                                1, 2, 3: m_rd = m_reg[insn_word[19:16]];
                                default: m_rd = 0;
                            endcase
                        end else begin
                            case (insn_word[19:16])
                                1: m_reg[1] = core_wdata & ((32'd1 << CW) - 1);
                                2, 3: m_reg[insn_word[19:16]] = core_wdata;
                                default: ;
                            endcase
                        end
                    end
                end else if (insn_word[27:24] == 4'hE || insn_word[27:25] == 3'b110)
                    m_trap = 1;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison with the model
    always @(negedge clk) begin
        if (rst_n && cycles > 1 && !done) begin
            check("R2", {31'b0, xfer_accept}, {31'b0, m_acc});
            check("R6", {31'b0, undef_trap}, {31'b0, m_trap});
            check("R3", core_rdata, m_rd);
            check("R8", {31'b0, xfer_accept & undef_trap}, 32'd0);
        end
    end

    function automatic logic [31:0] xf(input bit rd, input logic [3:0] crn, input logic [3:0] cp);
        return {4'hE, 4'hE, 3'b000, rd, crn, 4'h0, cp, 3'b000, 1'b1, 4'h0};
    endfunction

    task automatic op(input logic [31:0] w, input bit pm, input logic [31:0] wd);
        insn_valid = 1; insn_word = w; priv_mode = pm; core_wdata = wd;
        @(negedge clk);
        insn_valid = 0; insn_word = '0; core_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] crn, input logic [31:0] exp);
        op(xf(1, crn, 4'hF), 1, 0);
        check(tag, core_rdata, exp);
        check(tag, {31'b0, xfer_accept}, 32'd1);
    endtask

    task automatic do_reset(input bit v);
        vec_init = v; rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1;
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset(1);
        // R1: reset outputs and vector bit from pin
        check("R1", {30'b0, xfer_accept, undef_trap}, 32'd0);
        check("R1", core_rdata, 32'd0);
        rd_chk("R1", 1, 32'h0000_2000);
        rd_chk("R1", 2, 32'd0);
        do_reset(0);
        rd_chk("R1", 1, 32'd0);

        // R4 R12: write and read back
        op(xf(0, 2, 4'hF), 1, 32'hA5A5_1234);
        check("R4", {31'b0, xfer_accept}, 32'd1);
        rd_chk("R4", 2, 32'hA5A5_1234);
        op(xf(0, 3, 4'hF), 1, 32'h0F0F_F0F0);
        rd_chk("R12", 3, 32'h0F0F_F0F0);
        // R11: control keeps only low bits
        op(xf(0, 1, 4'hF), 1, 32'hFFFF_FFFF);
        rd_chk("R11", 1, 32'h0000_3FFF);

        // R5: unprivileged write and read trap, no change
        op(xf(0, 2, 4'hF), 0, 32'h0);
        check("R5", {30'b0, xfer_accept, undef_trap}, 32'd1);
        op(xf(1, 3, 4'hF), 0, 0);
        check("R5", {30'b0, xfer_accept, undef_trap}, 32'd1);
        check("R5", core_rdata, 32'h0000_3FFF);
        rd_chk("R5", 2, 32'hA5A5_1234);

        // R6: data op and memory transfers trap in both modes
        op({4'hE, 4'hE, 4'h0, 4'h2, 4'h0, 4'hF, 8'h00}, 1, 32'h0);
        check("R6", {30'b0, xfer_accept, undef_trap}, 32'd1);
        op({4'hE, 3'b110, 5'b00001, 4'h2, 4'h0, 4'hF, 8'h00}, 0, 32'h0);
        check("R6", {30'b0, xfer_accept, undef_trap}, 32'd1);
        op({4'hE, 3'b110, 5'b00000, 4'h3, 4'h0, 4'hF, 8'h00}, 1, 32'h0);
        check("R6", {30'b0, xfer_accept, undef_trap}, 32'd1);
        rd_chk("R6", 3, 32'h0F0F_F0F0);

        // R7: other coprocessor and non-coprocessor words ignored
        op(xf(0, 2, 4'hE), 1, 32'h0);
        check("R7", {30'b0, xfer_accept, undef_trap}, 32'd0);
        op(32'hE080_1F00, 1, 32'h0);
        check("R7", {30'b0, xfer_accept, undef_trap}, 32'd0);
        rd_chk("R7", 2, 32'hA5A5_1234);

        // R9 R10: identity and undefined registers
        op(xf(0, 0, 4'hF), 1, 32'hDEAD_BEEF);
        rd_chk("R9", 0, ID_V);
        op(xf(0, 7, 4'hF), 1, 32'hDEAD_BEEF);
        rd_chk("R10", 7, 32'd0);

        // R8: back-to-back strobes, then idle
        op(xf(1, 2, 4'hF), 1, 0);
        op(xf(0, 2, 4'hF), 0, 0);
        check("R8", {30'b0, xfer_accept, undef_trap}, 32'd1);
        @(negedge clk);
        check("R8", {30'b0, xfer_accept, undef_trap}, 32'd0);
        repeat (2) @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule